// File: doc/BRIEF.md
# Three-Wire Codec Control Master

This block is a synchronous bus master for a three-wire codec control link made of a clock line, a data line and a mode line. A host asks for one transaction at a time. It supplies a 6-bit device address, a 2-bit transfer type, a read/write flag and a flag that selects one or two data bytes. The master first sends an address byte with the mode line low. It then writes the data bytes, or reads them back from the codec, with the mode line high.

Every bus timing interval is a parameter counted in system clock cycles:

- clock-low time per bit
- clock-high time per bit
- halt pulse width
- setup wait before each byte
- hold wait after each byte

The host side is a one-cycle start request with a busy flag and a one-cycle done pulse. Write bytes arrive on two byte-wide input ports. Read bytes are returned on two byte-wide output ports. Each pin has a value output and an output-enable, so the pads can be built as tri-state buffers.

Top module: `twc_master`

## Requirements
- R1: The address byte is `{dev_addr_i, xfer_type_i}`, with the address in bits 7..2 and the type in bits 1..0. It is shifted as exactly 8 bits, bit 0 first, while the mode line is driven low.
- R2: In a write, each data byte is shifted as exactly 8 bits, bit 0 first, with the mode line high. The data line changes only while the clock line is low, and it is set in the same cycle the clock falls.
- R3: In a read, the data-line enable drops when the address byte has been sent. Each bit is sampled at the end of its clock-low interval, bit 0 first. After done, the first data byte is on `rdata0_o` and the second on `rdata1_o`.
- R4: In a two-byte transfer, one extra clock-low pulse of T_HALT cycles is inserted between the first byte's hold wait and the second byte's setup wait. A one-byte transfer has no such pulse.
- R5: Every bit's clock-low interval lasts T_LOW cycles. The clock is high for 1 + T_SETUP cycles from the start of a transaction to the first falling edge.
- R6: In the first busy cycle, clock, data and mode are all driven, and all three are high.
- R7: At the end of a transaction, all three enables drop in the same cycle. `done_o` is high in that cycle only.
- R8: A start request seen while `busy_o` is high is ignored. It causes no second transaction and does not alter the one in progress.
- R9: When `two_bytes_i` = 0, exactly one data byte (8 clock pulses with mode high) follows the address byte.
- R10: After reset, `busy_o` and `done_o` are low and all three pin enables are low.
- R11: The clock and mode enables stay high for every cycle that `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start request, sampled when idle |
| dev_addr_i | input | 6 | Device address |
| xfer_type_i | input | 2 | Transfer type code |
| rd_i | input | 1 | 1 = read, 0 = write |
| two_bytes_i | input | 1 | 1 = two data bytes, 0 = one |
| wdata0_i | input | 8 | First write byte |
| wdata1_i | input | 8 | Second write byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when the bus is released |
| rdata0_o | output | 8 | First read byte |
| rdata1_o | output | 8 | Second read byte |
| scl_o | output | 1 | Clock line value |
| scl_oe_o | output | 1 | Clock line enable |
| sda_o | output | 1 | Data line value |
| sda_oe_o | output | 1 | Data line enable |
| sda_i | input | 1 | Data line input |
| mode_o | output | 1 | Mode line value |
| mode_oe_o | output | 1 | Mode line enable |

## Verification
The hardest case to reach is a two-byte read. There the halt pulse has to be told apart from the bit pulses, and the responder has to put the right bit on the data line after each clock fall but not after the halt fall. The bench builds a responder that counts clock falls in the mode-high phase and skips fall number 8 when two bytes are expected. It sets the widths so that halt and bit pulses differ, which lets the monitor identify the halt from its measured width. A second start request is injected in the middle of a transaction. Any extra bus activity would then find an empty expectation queue.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int ADDR_W = 6;
    localparam int TYPE_W = 2;
    localparam int BYTE_W = ADDR_W + TYPE_W;
    localparam int BIT_W  = $clog2(BYTE_W);

    // byte slot inside a transaction
    localparam logic [1:0] SLOT_ADDR = 2'd0;
    localparam logic [1:0] SLOT_D0   = 2'd1;
    localparam logic [1:0] SLOT_D1   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_HALT
    } twc_state_e;

    typedef struct packed {
        twc_state_e         st;
        logic [1:0]         slot;
        logic [BIT_W-1:0]   bit_i;
        logic               rd;
        logic               two;
        logic [BYTE_W-1:0]  abyte;
        logic [BYTE_W-1:0]  w0;
        logic [BYTE_W-1:0]  w1;
        logic               scl;
        logic               sda;
        logic               mode;
        logic               scl_oe;
        logic               sda_oe;
        logic               mode_oe;
        logic               busy;
        logic               done;
    } twc_regs_t;

endpackage

// File: rtl/twc_tick.sv
module twc_tick #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/twc_rx_capture.sv
module twc_rx_capture
    import twc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic [1:0]        slot_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] rdata0_o,
    output logic [BYTE_W-1:0] rdata1_o
);
    logic [BYTE_W-1:0] r0_d, r0_q, r1_d, r1_q;

    always_comb begin
        r0_d = r0_q;
        r1_d = r1_q;
        if (sample_i) begin
            if (slot_i == SLOT_D0) r0_d[bit_i] = sda_i;
            else                   r1_d[bit_i] = sda_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r0_q <= '0;
            r1_q <= '0;
        end else begin
            r0_q <= r0_d;
            r1_q <= r1_d;
        end
    end

    assign rdata0_o = r0_q;
    assign rdata1_o = r1_q;
endmodule

// File: rtl/twc_master.sv
module twc_master
    import twc_pkg::*;
#(
    parameter int T_LOW   = 4,
    parameter int T_HIGH  = 4,
    parameter int T_HALT  = 8,
    parameter int T_SETUP = 4,
    parameter int T_HOLD  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [TYPE_W-1:0] xfer_type_i,
    input  logic              rd_i,
    input  logic              two_bytes_i,
    input  logic [BYTE_W-1:0] wdata0_i,
    input  logic [BYTE_W-1:0] wdata1_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rdata0_o,
    output logic [BYTE_W-1:0] rdata1_o,
    output logic              scl_o,
    output logic              scl_oe_o,
    output logic              sda_o,
    output logic              sda_oe_o,
    input  logic              sda_i,
    output logic              mode_o,
    output logic              mode_oe_o
);
    localparam int MAX_A = (T_LOW  > T_HIGH)  ? T_LOW  : T_HIGH;
    localparam int MAX_B = (T_HALT > T_SETUP) ? T_HALT : T_SETUP;
    localparam int MAX_C = (MAX_A  > MAX_B)   ? MAX_A  : MAX_B;
    localparam int MAX_T = (MAX_C  > T_HOLD)  ? MAX_C  : T_HOLD;
    localparam int TW    = $clog2(MAX_T + 1);

    localparam logic [TW-1:0] LD_LOW   = TW'(T_LOW - 1);
    localparam logic [TW-1:0] LD_HIGH  = TW'(T_HIGH - 1);
    localparam logic [TW-1:0] LD_HALT  = TW'(T_HALT - 1);
    localparam logic [TW-1:0] LD_SETUP = TW'(T_SETUP - 1);
    localparam logic [TW-1:0] LD_HOLD  = TW'(T_HOLD - 1);

    twc_regs_t        q, d;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_exp;
    logic             rx_sample;
    logic [BYTE_W-1:0] cur_byte;
    logic [BIT_W-1:0] nxt_bit;
    logic             sending;
    logic             last_slot;
    logic             rd_lat;

    twc_tick #(.W(TW)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    twc_rx_capture u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (rx_sample),
        .slot_i   (q.slot),
        .bit_i    (q.bit_i),
        .sda_i    (sda_i),
        .rdata0_o (rdata0_o),
        .rdata1_o (rdata1_o)
    );

    // byte currently on the wire
    always_comb begin
        case (q.slot)
            SLOT_ADDR: cur_byte = q.abyte;
            SLOT_D0:   cur_byte = q.w0;
            default:   cur_byte = q.w1;
        endcase
    end

    assign nxt_bit   = q.bit_i + 1'b1;
    assign sending   = (q.slot == SLOT_ADDR) || !q.rd;
    assign last_slot = (q.slot == SLOT_D1) || ((q.slot == SLOT_D0) && !q.two);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rx_sample = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.st      = ST_START;
                    d.slot    = SLOT_ADDR;
                    d.bit_i   = '0;
                    d.rd      = rd_i;
                    d.two     = two_bytes_i;
                    d.abyte   = {dev_addr_i, xfer_type_i};
                    d.w0      = wdata0_i;
                    d.w1      = wdata1_i;
                    d.scl     = 1'b1;
                    d.sda     = 1'b1;
                    d.mode    = 1'b1;
                    d.scl_oe  = 1'b1;
                    d.sda_oe  = 1'b1;
                    d.mode_oe = 1'b1;
                    d.busy    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = '0;
                end
            end
            ST_START: begin
                if (tmr_exp) begin
                    d.st     = ST_SETUP;
                    d.mode   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    d.st    = ST_LOW;
                    d.bit_i = '0;
                    d.scl   = 1'b0;
                    if (sending) d.sda = cur_byte[0];
                    tmr_load = 1'b1;
                    tmr_val  = LD_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    rx_sample = !sending;
                    d.st      = ST_HIGH;
                    d.scl     = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (q.bit_i == BIT_W'(BYTE_W - 1)) begin
                        d.st    = ST_HOLD;
                        d.scl   = 1'b1;
                        tmr_val = LD_HOLD;
                        if ((q.slot == SLOT_ADDR) && q.rd) d.sda_oe = 1'b0;
                    end else begin
                        d.st    = ST_LOW;
                        d.bit_i = nxt_bit;
                        d.scl   = 1'b0;
                        if (sending) d.sda = cur_byte[nxt_bit];
                        tmr_val = LD_LOW;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    if (q.slot != SLOT_ADDR && last_slot) begin
                        d.st      = ST_IDLE;
                        d.scl_oe  = 1'b0;
                        d.sda_oe  = 1'b0;
                        d.mode_oe = 1'b0;
                        d.busy    = 1'b0;
                        d.done    = 1'b1;
                    end else if (q.slot == SLOT_D0) begin
                        d.st     = ST_HALT;
                        d.slot   = SLOT_D1;
                        d.scl    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HALT;
                    end else begin
                        d.st     = ST_SETUP;
                        d.slot   = SLOT_D0;
                        d.mode   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SETUP;
                    end
                end
            end
            ST_HALT: begin
                if (tmr_exp) begin
                    d.st     = ST_SETUP;
                    d.scl    = 1'b1;
                    d.mode   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.scl     <= 1'b1;
            q.sda     <= 1'b1;
            q.mode    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign scl_o     = q.scl;
    assign scl_oe_o  = q.scl_oe;
    assign sda_o     = q.sda;
    assign sda_oe_o  = q.sda_oe;
    assign mode_o    = q.mode;
    assign mode_oe_o = q.mode_oe;
    assign rd_lat    = q.rd;
endmodule

// File: rtl/twc_master_chk.sv
module twc_master_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic busy_o,
    input logic done_o,
    input logic scl_o,
    input logic scl_oe_o,
    input logic sda_o,
    input logic sda_oe_o,
    input logic mode_o,
    input logic mode_oe_o,
    input logic rd_lat
);
    p_start_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_oe_o) |-> (scl_o && sda_o && mode_o && sda_oe_o && mode_oe_o));

    p_release_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_oe_o) |-> (done_o && !sda_oe_o && !mode_oe_o));

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_lines_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (scl_oe_o && mode_oe_o));

    p_sda_quiet_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_oe_o && $past(scl_oe_o) && scl_o && $past(scl_o)
         && sda_oe_o && $past(sda_oe_o)) |-> $stable(sda_o));

    p_read_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && rd_lat && mode_o) |-> !sda_oe_o);
endmodule

bind twc_master twc_master_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .scl_o     (scl_o),
    .scl_oe_o  (scl_oe_o),
    .sda_o     (sda_o),
    .sda_oe_o  (sda_oe_o),
    .mode_o    (mode_o),
    .mode_oe_o (mode_oe_o),
    .rd_lat    (rd_lat)
);

// File: tb/test_twc_master.sv
`timescale 1ns/1ps
module test_twc_master;
    localparam int T_LOW   = 3;
    localparam int T_HIGH  = 2;
    localparam int T_HALT  = 7;
    localparam int T_SETUP = 4;
    localparam int T_HOLD  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [5:0] dev_addr = '0;
    logic [1:0] xtype = '0;
    logic rd = 1'b0, two = 1'b0;
    logic [7:0] wd0 = '0, wd1 = '0;
    logic busy, done;
    logic [7:0] rd0, rd1;
    logic scl, scl_oe, sda, sda_oe, sda_in, mode, mode_oe;
    logic slave_bit = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign sda_in = sda_oe ? sda : slave_bit;

    twc_master #(
        .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HALT(T_HALT),
        .T_SETUP(T_SETUP), .T_HOLD(T_HOLD)
    ) i_twc_master (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req),
        .dev_addr_i(dev_addr), .xfer_type_i(xtype), .rd_i(rd),
        .two_bytes_i(two), .wdata0_i(wd0), .wdata1_i(wd1),
        .busy_o(busy), .done_o(done), .rdata0_o(rd0), .rdata1_o(rd1),
        .scl_o(scl), .scl_oe_o(scl_oe), .sda_o(sda), .sda_oe_o(sda_oe),
        .sda_i(sda_in), .mode_o(mode), .mode_oe_o(mode_oe)
    );

    typedef struct {
        logic [7:0] a;
        logic [7:0] d0;
        logic [7:0] d1;
        bit         rd;
        bit         two;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // ---------------- monitor / responder ----------------
    bit p_oe = 0, p_scl = 1, p_done = 0;
    exp_t cur;
    logic [7:0] a_obs, d0_obs, d1_obs;
    int arise, drise, dfall, lowcnt, precnt;
    bit seen_fall;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done && p_done) chk(0, "R7 done longer than one cycle", 1, 0);
            if (scl_oe && !p_oe) begin
                chk(scl && sda && mode && sda_oe && mode_oe, "R6 start lines high",
                    {scl, sda, mode, sda_oe, mode_oe}, 5'h1f);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected transaction", 1, 0);
                    cur = '{8'h00, 8'h00, 8'h00, 1'b0, 1'b0};
                end else begin
                    cur = exp_q[0];
                end
                arise = 0; drise = 0; dfall = 0; lowcnt = 0; precnt = 1;
                seen_fall = 0; a_obs = '0; d0_obs = '0; d1_obs = '0;
            end else if (scl_oe) begin
                if (!scl) begin
                    if (p_scl) begin
                        if (!seen_fall) begin
                            chk(precnt == 1 + T_SETUP, "R5 start-to-first-fall", precnt, 1 + T_SETUP);
                            seen_fall = 1;
                        end
                        if (mode && cur.rd) begin
                            if (dfall < 8)                 slave_bit = cur.d0[dfall];
                            else if (cur.two && dfall > 8) slave_bit = cur.d1[dfall - 9];
                            dfall++;
                        end
                    end
                    lowcnt++;
                end else begin
                    if (!seen_fall) precnt++;
                    if (!p_scl) begin
                        if (!mode) begin
                            chk(lowcnt == T_LOW, "R5 address bit low width", lowcnt, T_LOW);
                            if (arise < 8) a_obs[arise] = sda;
                            arise++;
                        end else if (cur.two && drise == 8) begin
                            chk(lowcnt == T_HALT, "R4 halt pulse width", lowcnt, T_HALT);
                            drise++;
                        end else begin
                            chk(lowcnt == T_LOW, "R5 data bit low width", lowcnt, T_LOW);
                            if (cur.rd) chk(!sda_oe, "R3 data line released in read", sda_oe, 0);
                            else if (drise < 8)  d0_obs[drise] = sda;
                            else if (drise < 17) d1_obs[drise - 9] = sda;
                            drise++;
                        end
                        lowcnt = 0;
                    end
                end
            end else if (p_oe) begin
                chk(done, "R7 done with release", done, 1);
                chk(!sda_oe && !mode_oe, "R7 all enables drop", {sda_oe, mode_oe}, 0);
                chk(a_obs == cur.a, "R1 address byte", a_obs, cur.a);
                chk(arise == 8, "R1 address bit count", arise, 8);
                if (cur.two) chk(drise == 17, "R4 pulses with halt", drise, 17);
                else         chk(drise == 8, "R9 single byte pulses", drise, 8);
                if (!cur.rd) begin
                    chk(d0_obs == cur.d0, "R2 first write byte", d0_obs, cur.d0);
                    if (cur.two) chk(d1_obs == cur.d1, "R2 second write byte", d1_obs, cur.d1);
                end
                if (exp_q.size() > 0) void'(exp_q.pop_front());
            end
            p_oe   = scl_oe;
            p_scl  = scl;
            p_done = done;
        end
    end

    // ---------------- driver ----------------
    task automatic xfer(input logic [5:0] a, input logic [1:0] t, input bit r, input bit tw,
                        input logic [7:0] b0, input logic [7:0] b1, input bit dup);
        exp_t e;
        e.a = {a, t}; e.d0 = b0; e.d1 = b1; e.rd = r; e.two = tw;
        exp_q.push_back(e);
        @(negedge clk);
        dev_addr = a; xtype = t; rd = r; two = tw; wd0 = b0; wd1 = b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy, "R8 busy after start", busy, 1);
        if (dup) begin
            repeat (6) @(negedge clk);
            dev_addr = ~a; xtype = ~t; rd = ~r; wd0 = ~b0; wd1 = ~b1; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        while (!done) @(negedge clk);
        if (r) begin
            chk(rd0 == b0, "R3 first read byte", rd0, b0);
            if (tw) chk(rd1 == b1, "R3 second read byte", rd1, b1);
        end
        @(negedge clk);
        chk(!done, "R7 done cleared", done, 0);
        chk(!busy, "R7 busy cleared", busy, 0);
        if (dup) begin
            repeat (10) @(negedge clk);
            chk(!scl_oe && !busy, "R8 no second transaction", {scl_oe, busy}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 reset handshake", {busy, done}, 0);
        chk(!scl_oe && !sda_oe && !mode_oe, "R10 reset enables", {scl_oe, sda_oe, mode_oe}, 0);

        xfer(6'h05, 2'd2, 0, 0, 8'hA6, 8'h00, 0);   // R9 one-byte write
        xfer(6'h3F, 2'd3, 0, 1, 8'h01, 8'h80, 0);   // R2 R4 two-byte write
        xfer(6'h14, 2'd0, 1, 0, 8'h5A, 8'h00, 0);   // R3 one-byte read
        xfer(6'h2A, 2'd1, 1, 1, 8'hC3, 8'h3C, 0);   // R3 R4 two-byte read
        xfer(6'h11, 2'd2, 0, 1, 8'h96, 8'h69, 1);   // R8 start while busy
        xfer(6'h00, 2'd0, 0, 1, 8'h00, 8'hFF, 0);   // R1 R2 extreme values
        xfer(6'h2B, 2'd1, 1, 1, 8'hFF, 8'h00, 1);   // R8 during a read

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all transactions seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule